// File: doc/BRIEF.md
# Control-IN Endpoint Transmit Packet Buffer

This block holds one outgoing packet for the IN direction of a USB device control endpoint. Software fills it one byte at a time through a write-only data port. It then pulses a commit strobe. Only after the commit does the serial engine see the bytes as a packet ready to send. Before any write, the byte contents are undefined.

The serial engine asks for data with an IN request. It reads the committed bytes in order and then reports how the host answered. An ACK frees the buffer and raises a sticky transmit-done flag. A timeout or missing handshake keeps the packet for a retry and restarts the readout at the first byte. A separate clear strobe empties the buffer at any time. Software clears the flag by writing a one to it.

Top module: `ctl_in_txbuf`

## Requirements
- R1: After reset, `sie_ready` is 0, `sie_pkt_len` is 0, `tx_done` is 0 and `sie_rd_data` is 0.
- R2: Bytes written while no packet is committed are stored in arrival order. After commit, `sie_rd_data` shows the byte at the read position, and each `sie_rd` pulse advances that position by one. Once all `sie_pkt_len` bytes are read, `sie_rd_data` is 0 and further `sie_rd` pulses have no effect.
- R3: At most DEPTH (8) bytes are accepted. Further writes are dropped, `sie_pkt_len` stays at DEPTH, and the dropped bytes never appear on `sie_rd_data`.
- R4: While a packet is committed, CPU writes and further commit pulses are ignored. Packet length and contents stay unchanged.
- R5: A commit with no bytes written sets `sie_ready` with `sie_pkt_len` 0, which is a zero-length packet.
- R6: `sie_nak` is high in the same cycle that `sie_in_req` is high while no packet is committed. It is low whenever a packet is committed.
- R7: `sie_ack` while a packet is committed does the following on the next cycle: `tx_done` is set, `sie_ready` drops and `sie_pkt_len` returns to 0.
- R8: `sie_fail` while a packet is committed keeps `sie_ready` and `sie_pkt_len` unchanged. It returns the read position to byte 0.
- R9: `buf_clr` discards written and committed data. On the next cycle `sie_ready` is 0 and `sie_pkt_len` is 0. `buf_clr` also overrides an ACK in the same cycle, and no flag is set.
- R10: `tx_done` stays set until `flag_clr_w1` is pulsed. A flag-setting ACK in the same cycle as `flag_clr_w1` wins, and the flag stays 1.
- R11: `sie_ack` and `sie_fail` while no packet is committed have no effect on `tx_done`, `sie_pkt_len` or `sie_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | Byte write strobe |
| cpu_wr_data | input | DW | Byte to append |
| cpu_commit | input | 1 | Packet-enable trigger |
| buf_clr | input | 1 | Buffer clear strobe |
| flag_clr_w1 | input | 1 | Write-one-to-clear for `tx_done` |
| sie_in_req | input | 1 | IN request from the serial engine |
| sie_rd | input | 1 | Advance the read position |
| sie_ack | input | 1 | Host returned ACK |
| sie_fail | input | 1 | Host timeout or no ACK |
| sie_ready | output | 1 | A committed packet is available |
| sie_pkt_len | output | $clog2(DEPTH+1) | Bytes held in the buffer |
| sie_rd_data | output | DW | Byte at the read position |
| sie_nak | output | 1 | NAK indication for the current IN request |
| tx_done | output | 1 | Sticky transmit-done flag (interrupt flag bit 0) |

## Verification
The bench builds the block with its defaults, DEPTH=8 and DW=8. With these values, eight writes fill the buffer, so the overflow edge at the ninth and tenth byte is reached in a few cycles. A 4-bit length also shows the full-buffer value 8 directly. A random phase then mixes strobes in the same cycle: clear with ACK, ACK with flag clear, and write with commit. Each ordering is compared every cycle against a queue-based model.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  function automatic bit room_left(int unsigned fill, int unsigned depth);
    return fill < depth;
  endfunction

  function automatic bit byte_pending(int unsigned rpos, int unsigned fill);
    return rpos < fill;
  endfunction
endpackage

// File: rtl/txbuf_store.sv
module txbuf_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr_en,
  input  logic          cpu_commit,
  input  logic          buf_clr,
  input  logic          sie_rd,
  input  logic          sie_ack,
  input  logic          sie_fail,
  output logic          ready,
  output logic [LW-1:0] fill,
  output logic [LW-1:0] rpos,
  output logic          wr_ev,
  output logic          ack_ev,
  output logic          fail_ev,
  output logic          rd_ev
);
  logic commit_ev;

  assign wr_ev     = cpu_wr_en & ~buf_clr & ~ready & room_left(fill, DEPTH);
  assign commit_ev = cpu_commit & ~buf_clr & ~ready;
  assign ack_ev    = sie_ack & ~buf_clr & ready;
  assign fail_ev   = sie_fail & ~buf_clr & ready & ~sie_ack;
  assign rd_ev     = sie_rd & ~buf_clr & ready & ~sie_ack & ~sie_fail
                   & byte_pending(rpos, fill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      fill  <= '0;
      rpos  <= '0;
    end else if (buf_clr || ack_ev) begin
      ready <= 1'b0;
      fill  <= '0;
      rpos  <= '0;
    end else begin
      if (wr_ev)     fill  <= fill + 1'b1;
      if (commit_ev) begin
        ready <= 1'b1;
        rpos  <= '0;
      end
      if (fail_ev)   rpos  <= '0;
      else if (rd_ev) rpos <= rpos + 1'b1;
    end
  end
endmodule

// File: rtl/txbuf_irq.sv
module txbuf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_w1,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_w1) flag <= 1'b0;
  end
endmodule

// File: rtl/ctl_in_txbuf.sv
module ctl_in_txbuf
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr_en,
  input  logic [DW-1:0] cpu_wr_data,
  input  logic          cpu_commit,
  input  logic          buf_clr,
  input  logic          flag_clr_w1,
  input  logic          sie_in_req,
  input  logic          sie_rd,
  input  logic          sie_ack,
  input  logic          sie_fail,
  output logic          sie_ready,
  output logic [LW-1:0] sie_pkt_len,
  output logic [DW-1:0] sie_rd_data,
  output logic          sie_nak,
  output logic          tx_done
);
  logic          ready;
  logic [LW-1:0] fill;
  logic [LW-1:0] rpos;
  logic          wr_ev, ack_ev, fail_ev, rd_ev;
  logic [DW-1:0] cell_q;

  txbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_commit(cpu_commit), .buf_clr(buf_clr),
    .sie_rd(sie_rd), .sie_ack(sie_ack), .sie_fail(sie_fail),
    .ready(ready), .fill(fill), .rpos(rpos),
    .wr_ev(wr_ev), .ack_ev(ack_ev), .fail_ev(fail_ev), .rd_ev(rd_ev)
  );

  txbuf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .we(wr_ev), .waddr(fill[AW-1:0]), .wdata(cpu_wr_data),
    .raddr(rpos[AW-1:0]), .rdata(cell_q)
  );

  txbuf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(ack_ev), .clr_w1(flag_clr_w1),
    .flag(tx_done)
  );

  assign sie_ready   = ready;
  assign sie_pkt_len = fill;
  assign sie_nak     = sie_in_req & ~ready;
  assign sie_rd_data = (ready && byte_pending(rpos, fill)) ? cell_q : '0;
endmodule

// File: rtl/txbuf_chk.sv
module txbuf_chk #(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_ev,
  input logic          fail_ev,
  input logic          buf_clr,
  input logic          flag_clr_w1,
  input logic          ready,
  input logic [LW-1:0] fill,
  input logic [LW-1:0] rpos,
  input logic          tx_done
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= LW'(DEPTH));

  a_r4_frozen_len: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !ack_ev && !buf_clr |=> $stable(fill) && ready);

  a_r7_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ev |=> !ready && fill == '0 && tx_done);

  a_r8_fail_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev |=> ready && rpos == '0 && $stable(fill));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clr |=> !ready && fill == '0);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !flag_clr_w1 |=> tx_done);

  a_r2_read_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rpos <= fill);
endmodule

bind ctl_in_txbuf txbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_ev(ack_ev), .fail_ev(fail_ev),
  .buf_clr(buf_clr), .flag_clr_w1(flag_clr_w1), .ready(ready),
  .fill(fill), .rpos(rpos), .tx_done(tx_done)
);

// File: tb/tb_ctl_in_txbuf.sv
module tb_ctl_in_txbuf;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic cpu_wr_en = 0, cpu_commit = 0, buf_clr = 0, flag_clr_w1 = 0;
  logic sie_in_req = 0, sie_rd = 0, sie_ack = 0, sie_fail = 0;
  logic [DW-1:0] cpu_wr_data = 0;
  logic          sie_ready, sie_nak, tx_done;
  logic [LW-1:0] sie_pkt_len;
  logic [DW-1:0] sie_rd_data;

  always #2 clk = ~clk;

  ctl_in_txbuf #(.DEPTH(DEPTH), .DW(DW)) dut (.*);

  byte unsigned q[$];
  bit  m_comm = 0, m_flag = 0;
  int  m_rp = 0;
  int  checks = 0, fails = 0;
  string phase = "R1";
  bit  done = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic tick();
    int exp_rd;
    #1;
    exp_rd = (m_comm && m_rp < q.size()) ? int'(q[m_rp]) : 0;
    chk("ready", int'(sie_ready), int'(m_comm));
    chk("len", int'(sie_pkt_len), q.size());
    chk("rd_data", int'(sie_rd_data), exp_rd);
    chk("nak", int'(sie_nak), int'(sie_in_req && !m_comm));
    chk("tx_done", int'(tx_done), int'(m_flag));
    @(posedge clk);
    begin
      bit set = 0;
      if (buf_clr) begin
        m_comm = 0; q.delete(); m_rp = 0;
      end else if (m_comm) begin
        if (sie_ack) begin
          m_comm = 0; q.delete(); m_rp = 0; set = 1;
        end else if (sie_fail) m_rp = 0;
        else if (sie_rd && m_rp < q.size()) m_rp++;
      end else begin
        if (cpu_wr_en && q.size() < DEPTH) q.push_back(cpu_wr_data);
        if (cpu_commit) begin m_comm = 1; m_rp = 0; end
      end
      if (set) m_flag = 1;
      else if (flag_clr_w1) m_flag = 0;
    end
    @(negedge clk);
    {cpu_wr_en, cpu_commit, buf_clr, flag_clr_w1} = '0;
    {sie_in_req, sie_rd, sie_ack, sie_fail} = '0;
  endtask

  task automatic wr(byte unsigned d);
    cpu_wr_en = 1; cpu_wr_data = d; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1"; tick();
    rst_n = 1;
    phase = "R1"; tick();
    phase = "R6"; sie_in_req = 1; tick();
    phase = "R2";
    wr(8'hA1); wr(8'hB2); wr(8'hC3);
    cpu_commit = 1; tick();
    phase = "R6"; sie_in_req = 1; tick();
    phase = "R2";
    repeat (4) begin sie_rd = 1; tick(); end
    phase = "R8"; sie_fail = 1; tick();
    tick();
    sie_rd = 1; tick();
    phase = "R4"; wr(8'h55); cpu_commit = 1; tick();
    phase = "R7"; sie_ack = 1; tick(); tick();
    phase = "R10"; flag_clr_w1 = 1; tick(); tick();
    phase = "R11"; sie_ack = 1; tick(); sie_fail = 1; tick();
    phase = "R10"; wr(8'h11); cpu_commit = 1; tick();
    sie_ack = 1; flag_clr_w1 = 1; tick(); tick();
    flag_clr_w1 = 1; tick();
    phase = "R5"; cpu_commit = 1; tick(); sie_rd = 1; tick();
    sie_ack = 1; tick();
    phase = "R3";
    for (int i = 0; i < 10; i++) wr(byte'(8'h20 + i));
    cpu_commit = 1; tick();
    for (int i = 0; i < 9; i++) begin sie_rd = 1; tick(); end
    phase = "R9"; buf_clr = 1; tick(); tick();
    wr(8'h77); cpu_commit = 1; tick();
    buf_clr = 1; sie_ack = 1; tick(); tick();
    phase = "R9";
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      cpu_wr_en   = (r % 3) == 0;
      cpu_wr_data = byte'($urandom);
      cpu_commit  = r < 8;
      sie_rd      = (r % 2) == 1;
      sie_ack     = r > 93;
      sie_fail    = r > 88 && r < 93;
      buf_clr     = r == 50;
      flag_clr_w1 = r > 80 && r < 86;
      sie_in_req  = r > 60;
      tick();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule